// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes a stream of zero-address instructions. Arithmetic instructions carry no operand field: both sources and the destination are implied by the stack. Only three instructions carry an operand. Push-literal carries an immediate constant. Push-from-memory and pop-to-memory each carry a data-memory address. The unit fetches one instruction per program counter value from a combinational program ROM port. It talks to a synchronous data memory whose reads return one cycle after the address is presented.

The upper stack entries live in a small register file that acts as a stack cache, so add and multiply never touch memory when their operands are cached. Once the cache is full, further pushes first move the oldest cached entry into an internal spill store. An operation whose operands have been spilled first brings them back one at a time. Each such spill or fill costs one cycle, during which the program counter holds.

A halt instruction, a stack underflow or a stack overflow stops the unit permanently until reset. The two error conditions are reported on sticky flags.

Top module: `zstack_core`

## Requirements
- R1: After synchronous reset the program counter is 0, halt, overflow and underflow are low, the stack is empty, and no data-memory write is issued.
- R2: An instruction is 19 bits. Bits [18:16] are the opcode and bits [15:0] are the operand; addresses use the low 8 operand bits. The opcodes are 0 halt, 1 push-from-memory, 2 push-literal, 3 add, 4 multiply and 5 pop-to-memory. Codes 6 and 7 do nothing except advance the program counter by one.
- R3: Push-literal places the operand on top of the stack. Push-from-memory presents its address with a read strobe in one cycle and pushes the returned word in the next. In both cases the program counter advances when the value lands.
- R4: Add and multiply remove the two top entries and push one result, which is the low 16 bits of the sum or product.
- R5: Pop-to-memory drives the write strobe for exactly one cycle, with the top entry as write data and the operand address. It removes that entry and advances the program counter.
- R6: The cache holds 4 entries and the spill store holds 8 more. A push that finds the cache full first spends one cycle moving the oldest cached entry to the spill store. An operation whose operands are not cached spends one cycle per entry refilled. Last-in-first-out order is preserved across spills.
- R7: Add or multiply with fewer than two entries, or pop with an empty stack, raises the underflow flag and halts. No memory write is issued and the program counter stays on the faulting instruction.
- R8: A push when 12 entries are held raises the overflow flag and halts, with the program counter left on the faulting instruction.
- R9: Once halted, by the halt opcode or by a fault, the halt output stays high, the program counter is frozen and no write strobe is issued until reset.
- R10: The program push a, push-literal 145, push b, add, multiply, pop res leaves a*(145+b) (low 16 bits) at address res.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 8 | Program counter, address to program ROM |
| instr_i | input | 19 | Instruction word at pc_o |
| dm_addr_o | output | 8 | Data-memory address |
| dm_re_o | output | 1 | Data-memory read strobe |
| dm_we_o | output | 1 | Data-memory write strobe |
| dm_wdata_o | output | 16 | Data-memory write data |
| dm_rdata_i | input | 16 | Data-memory read data, one cycle after the read |
| halt_o | output | 1 | Unit stopped |
| ovf_o | output | 1 | Sticky stack overflow flag |
| unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The embedded assertions check the following on every cycle:
- a halted unit stays halted, with a frozen program counter and no writes;
- every write advances the program counter;
- a read strobe is followed by a wait cycle with no new read;
- the underflow flag only rises together with halt, and overflow only at full capacity;
- spill and fill commands occur only with a full cache or a non-empty spill store.

Only the bench scenarios can show the rest. That covers the values that reach memory, the exact stall counts of spill and fill sequences, and stack order being kept across the register/memory boundary. It also covers 16-bit wrap of sums and products and the no-op opcodes. The bench follows these through a behavioural model compared every cycle, plus end-of-program memory checks.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;

    localparam int WORD_W  = 16;
    localparam int OP_W    = 3;
    localparam int INSTR_W = WORD_W + OP_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_HALT  = 3'd0,
        OP_PUSHM = 3'd1,
        OP_PUSHL = 3'd2,
        OP_ADD   = 3'd3,
        OP_MUL   = 3'd4,
        OP_POPM  = 3'd5,
        OP_NOPA  = 3'd6,
        OP_NOPB  = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        SC_IDLE,
        SC_PUSH,
        SC_POP,
        SC_COMBINE,
        SC_SPILL,
        SC_FILL
    } scmd_e;

    typedef enum logic [1:0] {
        ST_EXEC,
        ST_RDWAIT,
        ST_HALT
    } state_e;

    typedef struct packed {
        opcode_e op;
        word_t   imm;
        logic    is_push;
        logic    is_bin;
        logic    is_pop;
    } dec_t;

    function automatic word_t alu(opcode_e op, word_t lhs, word_t rhs);
        logic [2*WORD_W-1:0] prod;
        prod = lhs * rhs;
        if (op == OP_MUL) return prod[WORD_W-1:0];
        return lhs + rhs;
    endfunction

endpackage

// File: rtl/stk_decode.sv
`timescale 1ns/1ps
module stk_decode
    import stk_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    opcode_e op;

    assign op = opcode_e'(instr[INSTR_W-1 -: OP_W]);

    always_comb begin
        dec.op      = op;
        dec.imm     = instr[WORD_W-1:0];
        dec.is_push = (op == OP_PUSHM) || (op == OP_PUSHL);
        dec.is_bin  = (op == OP_ADD) || (op == OP_MUL);
        dec.is_pop  = (op == OP_POPM);
    end
endmodule

// File: rtl/stk_spill_mem.sv
`timescale 1ns/1ps
module stk_spill_mem
    import stk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/stk_cache.sv
`timescale 1ns/1ps
module stk_cache
    import stk_pkg::*;
#(
    parameter int CACHE_N = 4,
    parameter int SPILL_D = 8,
    localparam int CW  = $clog2(CACHE_N + 1),
    localparam int SW  = $clog2(SPILL_D + 1),
    localparam int SAW = (SPILL_D > 1) ? $clog2(SPILL_D) : 1,
    localparam int TW  = $clog2(CACHE_N + SPILL_D + 1)
) (
    input  logic    clk,
    input  logic    rst,
    input  scmd_e   cmd,
    input  word_t   push_val,
    input  opcode_e alu_op,
    output word_t   top_o,
    output logic [CW-1:0] cnt_o,
    output logic [TW-1:0] total_o
);
    logic [CW-1:0] cc;
    logic [SW-1:0] sc;
    logic [SW-1:0] sc_m1;
    word_t ent [CACHE_N];
    word_t top, sec, alu_res, fill_data;

    always_comb begin
        top = '0;
        sec = '0;
        for (int i = 0; i < CACHE_N; i++) begin
            if (int'(cc) == i + 1) top = ent[i];
            if (int'(cc) == i + 2) sec = ent[i];
        end
    end

    assign alu_res = alu(alu_op, sec, top);
    assign sc_m1   = sc - SW'(1);

    stk_spill_mem #(.DEPTH(SPILL_D)) u_spill (
        .clk   (clk),
        .we    (cmd == SC_SPILL),
        .waddr (sc[SAW-1:0]),
        .wdata (ent[0]),
        .raddr (sc_m1[SAW-1:0]),
        .rdata (fill_data)
    );

    for (genvar i = 0; i < CACHE_N; i++) begin : g_ent
        word_t q, from_above, from_below;
        if (i == CACHE_N - 1) begin : g_hi
            assign from_above = q;
        end else begin : g_mid
            assign from_above = ent[i+1];
        end
        if (i == 0) begin : g_lo
            assign from_below = fill_data;
        end else begin : g_up
            assign from_below = ent[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                case (cmd)
                    SC_PUSH:    if (int'(cc) == i)     q <= push_val;
                    SC_COMBINE: if (int'(cc) == i + 2) q <= alu_res;
                    SC_SPILL:   q <= from_above;
                    SC_FILL:    q <= from_below;
                    default:    ;
                endcase
            end
        end
        assign ent[i] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cc <= '0;
            sc <= '0;
        end else begin
            case (cmd)
                SC_PUSH:    cc <= cc + CW'(1);
                SC_POP:     cc <= cc - CW'(1);
                SC_COMBINE: cc <= cc - CW'(1);
                SC_SPILL: begin
                    cc <= cc - CW'(1);
                    sc <= sc + SW'(1);
                end
                SC_FILL: begin
                    cc <= cc + CW'(1);
                    sc <= sc - SW'(1);
                end
                default: ;
            endcase
        end
    end

    assign top_o   = top;
    assign cnt_o   = cc;
    assign total_o = TW'(cc) + TW'(sc);

    // R6: a spill happens only from a full cache into a store with room
    a_r6_spill_when_full: assert property (@(posedge clk) disable iff (rst)
        (cmd == SC_SPILL) |-> (int'(cc) == CACHE_N) && (int'(sc) < SPILL_D));

    // R6: a fill happens only when spilled entries exist and the cache has room
    a_r6_fill_has_source: assert property (@(posedge clk) disable iff (rst)
        (cmd == SC_FILL) |-> (sc != '0) && (int'(cc) < CACHE_N));

    // R4: combining needs two cached operands
    a_r4_combine_two_cached: assert property (@(posedge clk) disable iff (rst)
        (cmd == SC_COMBINE) |-> (int'(cc) >= 2));
endmodule

// File: rtl/zstack_core.sv
`timescale 1ns/1ps
module zstack_core
    import stk_pkg::*;
#(
    parameter int AW      = 8,
    parameter int PCW     = 8,
    parameter int CACHE_N = 4,
    parameter int SPILL_D = 8,
    localparam int CW  = $clog2(CACHE_N + 1),
    localparam int TW  = $clog2(CACHE_N + SPILL_D + 1),
    localparam int CAP = CACHE_N + SPILL_D
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PCW-1:0]     pc_o,
    input  logic [INSTR_W-1:0] instr_i,
    output logic [AW-1:0]      dm_addr_o,
    output logic               dm_re_o,
    output logic               dm_we_o,
    output logic [WORD_W-1:0]  dm_wdata_o,
    input  logic [WORD_W-1:0]  dm_rdata_i,
    output logic               halt_o,
    output logic               ovf_o,
    output logic               unf_o
);
    state_e state, state_nx;
    logic [PCW-1:0] pc;
    logic ovf, unf, set_ovf, set_unf, pc_adv;
    dec_t dec;
    scmd_e cmd;
    word_t push_val, top;
    logic [CW-1:0] cc;
    logic [TW-1:0] total;

    stk_decode u_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    stk_cache #(.CACHE_N(CACHE_N), .SPILL_D(SPILL_D)) u_cache (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .push_val (push_val),
        .alu_op   (dec.op),
        .top_o    (top),
        .cnt_o    (cc),
        .total_o  (total)
    );

    always_comb begin
        state_nx = state;
        cmd      = SC_IDLE;
        push_val = dec.imm;
        pc_adv   = 1'b0;
        set_ovf  = 1'b0;
        set_unf  = 1'b0;
        dm_re_o  = 1'b0;
        dm_we_o  = 1'b0;
        unique case (state)
            ST_HALT: ;
            ST_RDWAIT: begin
                cmd      = SC_PUSH;
                push_val = dm_rdata_i;
                pc_adv   = 1'b1;
                state_nx = ST_EXEC;
            end
            default: begin
                if (dec.op == OP_HALT) begin
                    state_nx = ST_HALT;
                end else if (dec.is_push) begin
                    if (int'(total) == CAP) begin
                        set_ovf  = 1'b1;
                        state_nx = ST_HALT;
                    end else if (int'(cc) == CACHE_N) begin
                        cmd = SC_SPILL;
                    end else if (dec.op == OP_PUSHL) begin
                        cmd    = SC_PUSH;
                        pc_adv = 1'b1;
                    end else begin
                        dm_re_o  = 1'b1;
                        state_nx = ST_RDWAIT;
                    end
                end else if (dec.is_bin) begin
                    if (int'(total) < 2) begin
                        set_unf  = 1'b1;
                        state_nx = ST_HALT;
                    end else if (int'(cc) < 2) begin
                        cmd = SC_FILL;
                    end else begin
                        cmd    = SC_COMBINE;
                        pc_adv = 1'b1;
                    end
                end else if (dec.is_pop) begin
                    if (total == '0) begin
                        set_unf  = 1'b1;
                        state_nx = ST_HALT;
                    end else if (cc == '0) begin
                        cmd = SC_FILL;
                    end else begin
                        cmd     = SC_POP;
                        dm_we_o = 1'b1;
                        pc_adv  = 1'b1;
                    end
                end else begin
                    pc_adv = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_EXEC;
            pc    <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            state <= state_nx;
            if (pc_adv)  pc  <= pc + PCW'(1);
            if (set_ovf) ovf <= 1'b1;
            if (set_unf) unf <= 1'b1;
        end
    end

    assign pc_o       = pc;
    assign dm_addr_o  = dec.imm[AW-1:0];
    assign dm_wdata_o = top;
    assign halt_o     = (state == ST_HALT);
    assign ovf_o      = ovf;
    assign unf_o      = unf;

    // R9: halt is final until reset, with a frozen program counter
    a_r9_halt_holds: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> halt_o && $stable(pc_o));

    // R9: no write while halted
    a_r9_no_write_halted: assert property (@(posedge clk) disable iff (rst)
        halt_o |-> !dm_we_o);

    // R5: each write retires its instruction
    a_r5_write_advances: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |=> pc_o == $past(pc_o) + PCW'(1));

    // R3: a read is followed by a wait cycle with no new read and a held pc
    a_r3_read_wait: assert property (@(posedge clk) disable iff (rst)
        dm_re_o |=> !dm_re_o && $stable(pc_o));

    // R7: underflow always comes with halt
    a_r7_unf_halts: assert property (@(posedge clk) disable iff (rst)
        $rose(unf_o) |-> halt_o && !ovf_o);

    // R8: overflow only when the stack was at capacity
    a_r8_ovf_at_cap: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> halt_o && (int'($past(total)) == CAP));
endmodule

// File: tb/zstack_core_test.sv
`timescale 1ns/1ps
module zstack_core_test;
    localparam int CAP = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pc;
    logic [18:0] instr;
    logic [7:0]  dm_addr;
    logic        dm_re, dm_we;
    logic [15:0] dm_wdata;
    logic [15:0] dm_rdata = '0;
    logic        halt, ovf, unf;

    logic [18:0] rom  [0:255];
    logic [15:0] dmem [0:255];
    logic [15:0] mdm  [0:255];

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    int stk[$];
    int m_cc, m_pc, m_st, m_raddr;
    bit m_ovf, m_unf;

    always #2.5 clk = ~clk;

    assign instr = rom[pc];

    always @(posedge clk) begin
        if (dm_we) dmem[dm_addr] <= dm_wdata;
        dm_rdata <= dmem[dm_addr];
    end

    zstack_core uut (
        .clk        (clk),
        .rst        (rst),
        .pc_o       (pc),
        .instr_i    (instr),
        .dm_addr_o  (dm_addr),
        .dm_re_o    (dm_re),
        .dm_we_o    (dm_we),
        .dm_wdata_o (dm_wdata),
        .dm_rdata_i (dm_rdata),
        .halt_o     (halt),
        .ovf_o      (ovf),
        .unf_o      (unf)
    );

    function automatic logic [18:0] enc(int op, int imm);
        return {op[2:0], imm[15:0]};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic mstep(bit rstv);
        logic [18:0] iw;
        int op, imm, d, a, b;
        longint r;
        if (rstv) begin
            stk.delete();
            m_cc = 0; m_pc = 0; m_st = 0; m_ovf = 0; m_unf = 0; m_raddr = 0;
            return;
        end
        if (m_st == 1) begin
            stk.push_back(int'(mdm[m_raddr]));
            m_cc++;
            m_pc = (m_pc + 1) & 255;
            m_st = 0;
        end else if (m_st == 0) begin
            iw  = rom[m_pc];
            op  = int'(iw[18:16]);
            imm = int'(iw[15:0]);
            d   = stk.size();
            case (op)
                0: m_st = 2;
                1, 2: begin
                    if (d == CAP) begin m_ovf = 1; m_st = 2; end
                    else if (m_cc == 4) m_cc = 3;
                    else if (op == 2) begin
                        stk.push_back(imm); m_cc++; m_pc = (m_pc + 1) & 255;
                    end else begin
                        m_raddr = imm & 255; m_st = 1;
                    end
                end
                3, 4: begin
                    if (d < 2) begin m_unf = 1; m_st = 2; end
                    else if (m_cc < 2) m_cc++;
                    else begin
                        b = stk.pop_back();
                        a = stk.pop_back();
                        r = (op == 3) ? longint'(a) + longint'(b) : longint'(a) * longint'(b);
                        stk.push_back(int'(r & 64'hFFFF));
                        m_cc--;
                        m_pc = (m_pc + 1) & 255;
                    end
                end
                5: begin
                    if (d < 1) begin m_unf = 1; m_st = 2; end
                    else if (m_cc == 0) m_cc++;
                    else begin
                        mdm[imm & 255] = 16'(stk.pop_back());
                        m_cc--;
                        m_pc = (m_pc + 1) & 255;
                    end
                end
                default: m_pc = (m_pc + 1) & 255;
            endcase
        end
    endtask

    task automatic compare();
        logic [18:0] iw;
        bit exp_we;
        iw = rom[m_pc];
        exp_we = (m_st == 0) && (iw[18:16] == 3'd5) && (stk.size() >= 1) && (m_cc >= 1);
        chk("R6", "pc", int'(pc), m_pc);
        chk("R9", "halt", int'(halt), int'(m_st == 2));
        chk("R8", "ovf", int'(ovf), int'(m_ovf));
        chk("R7", "unf", int'(unf), int'(m_unf));
        chk("R5", "write strobe", int'(dm_we), int'(exp_we));
        if (exp_we && dm_we) begin
            chk("R5", "write addr", int'(dm_addr), int'(iw[7:0]));
            chk("R5", "write data", int'(dm_wdata), stk[$]);
        end
    endtask

    task automatic tick(bit rstv);
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
        compare();
        rst = rstv;
        mstep(rstv);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 256; i++) begin
            rom[i]  = enc(0, 0);
            dmem[i] = '0;
            mdm[i]  = '0;
        end
    endtask

    task automatic poke(int a, int v);
        dmem[a] = 16'(v);
        mdm[a]  = 16'(v);
    endtask

    task automatic run_prog(string name);
        int n;
        tick(1);
        tick(1);
        n = 0;
        while (m_st != 2 && n < 400) begin
            tick(0);
            n++;
        end
        if (m_st != 2) chk("R9", {name, " reached halt"}, 0, 1);
        for (int k = 0; k < 3; k++) tick(0);
    endtask

    initial begin
        int p;
        clear_all();
        mstep(1);

        // R1: reset state observed at the ports
        tick(1);
        tick(1);
        chk("R1", "reset pc", int'(pc), 0);
        chk("R1", "reset halt", int'(halt), 0);
        chk("R1", "reset ovf", int'(ovf), 0);
        chk("R1", "reset unf", int'(unf), 0);
        chk("R1", "reset write", int'(dm_we), 0);

        // R10: a*(145+b)
        clear_all();
        poke(10, 7); poke(11, 3);
        rom[0] = enc(1, 10); rom[1] = enc(2, 145); rom[2] = enc(1, 11);
        rom[3] = enc(3, 0);  rom[4] = enc(4, 0);   rom[5] = enc(5, 20);
        rom[6] = enc(0, 0);
        run_prog("sample");
        chk("R10", "a*(145+b)", int'(dmem[20]), 1036);

        // R6: deep sum, spills and fills
        clear_all();
        for (int i = 0; i < 10; i++) rom[i] = enc(2, i + 1);
        for (int i = 0; i < 9; i++) rom[10 + i] = enc(3, 0);
        rom[19] = enc(5, 30);
        run_prog("deep sum");
        chk("R6", "sum 1..10 through spill", int'(dmem[30]), 55);

        // R6: LIFO order across the spill boundary
        clear_all();
        for (int i = 0; i < 6; i++) rom[i] = enc(2, i + 1);
        for (int i = 0; i < 6; i++) rom[6 + i] = enc(5, 40 + i);
        run_prog("lifo");
        for (int i = 0; i < 6; i++) chk("R6", "lifo order", int'(dmem[40 + i]), 6 - i);

        // R8: overflow on 13th push
        clear_all();
        for (int i = 0; i < 13; i++) rom[i] = enc(2, 100 + i);
        run_prog("overflow");
        chk("R8", "ovf flag", int'(ovf), 1);
        chk("R8", "pc at fault", int'(pc), 12);

        // R7: add with one entry
        clear_all();
        rom[0] = enc(2, 5); rom[1] = enc(3, 0);
        run_prog("underflow add");
        chk("R7", "unf flag", int'(unf), 1);
        chk("R7", "pc at fault", int'(pc), 1);

        // R7: pop on empty writes nothing
        clear_all();
        poke(9, 77);
        rom[0] = enc(5, 9);
        run_prog("underflow pop");
        chk("R7", "unf flag pop", int'(unf), 1);
        chk("R7", "pc at pop fault", int'(pc), 0);
        chk("R7", "memory untouched", int'(dmem[9]), 77);

        // R4 and R3: wrap of sum and product, push from memory
        clear_all();
        poke(5, 16'hBEEF);
        p = 0;
        rom[p++] = enc(2, 16'h1234); rom[p++] = enc(2, 16'h0100); rom[p++] = enc(4, 0); rom[p++] = enc(5, 60);
        rom[p++] = enc(2, 16'hFFFF); rom[p++] = enc(2, 16'hFFFF); rom[p++] = enc(4, 0); rom[p++] = enc(5, 61);
        rom[p++] = enc(2, 16'hFFFF); rom[p++] = enc(2, 2);        rom[p++] = enc(3, 0); rom[p++] = enc(5, 62);
        rom[p++] = enc(1, 5);        rom[p++] = enc(5, 63);
        run_prog("arith");
        chk("R4", "mul low bits", int'(dmem[60]), 16'h3400);
        chk("R4", "mul ffff*ffff", int'(dmem[61]), 1);
        chk("R4", "add wrap", int'(dmem[62]), 1);
        chk("R3", "push from memory", int'(dmem[63]), 16'hBEEF);

        // R2 and R9: unused opcodes skip, halt freezes pc
        clear_all();
        rom[0] = enc(2, 9); rom[1] = enc(6, 0); rom[2] = enc(7, 50); rom[3] = enc(5, 50);
        run_prog("nop");
        chk("R2", "nop value", int'(dmem[50]), 9);
        chk("R9", "pc frozen at halt", int'(pc), 4);
        chk("R9", "halt held", int'(halt), 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule